// File: doc/BRIEF.md
# Thread-Block Context Slot Allocator

This block sits in front of a compute core and places incoming thread blocks into the core's fixed set of block context slots. When a placement request arrives, it picks the lowest-numbered free slot allowed by the current occupancy limit and marks that slot busy. It then works out which span of hardware threads the block will use and which hardware warps cover that span. The number of resident blocks is kept up to date as slots are taken and given back.

A slot's position in the thread space is fixed: it starts at the slot index times the padded block size. The padded size is the block size rounded up to a whole warp, and the caller supplies it. The thread span ends, exclusively, at the start plus the real (unpadded) block size. The warp span runs from the warp that holds the first thread up to the end thread rounded up to a whole warp. With the default 2048 threads and 32-thread warps, the core has 64 hardware warps. A completion port frees a slot so that it can be used again.

Top module: `blk_slot_alloc`

## Requirements
- R1: A request takes the lowest-indexed free slot whose index is below both the `max_blocks` input and the `MAX_SLOTS` parameter. A `max_blocks` of 0 allows no slot.
- R2: A request that finds no allowed free slot pulses `deny` for one cycle. It changes no slot state, does not move `active_cnt`, and leaves the result outputs unchanged.
- R3: On a grant, `start_thread` equals the slot index multiplied by `padded_threads`.
- R4: On a grant, `end_thread` equals `start_thread` plus `blk_threads`, and is exclusive.
- R5: On a grant, `start_warp` is `start_thread` divided by `WARP_SIZE`, rounded down. `end_warp` is `end_thread` divided by `WARP_SIZE`, rounded up. With the default sizes the last slot can reach warp 64.
- R6: Each grant adds one to `active_cnt`. A release of a busy slot frees that slot and subtracts one from the count.
- R7: A release and a request in the same cycle both take effect. The request searches the slot states as they stood before that release, so a slot freed in this cycle can only be taken from the next cycle on.
- R8: A release naming a slot that is already free is ignored, and `active_cnt` does not change.
- R9: After reset all slots are free, `active_cnt` is 0, and `grant`, `deny` and every result output are 0.
- R10: `grant` or `deny` rises in the cycle after the request. The slot ID and the thread and warp results are valid with `grant` and hold until the next grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Placement request for one thread block |
| blk_threads | input | THR_W | Block size in threads |
| padded_threads | input | THR_W | Block size rounded up to a whole warp |
| max_blocks | input | CNT_W | Per-core limit on resident blocks |
| rel_valid | input | 1 | Release a slot |
| rel_slot | input | SLOT_W | Slot to release |
| grant | output | 1 | Request placed (one-cycle pulse) |
| deny | output | 1 | Request refused because no slot was free (one-cycle pulse) |
| slot_id | output | SLOT_W | Slot given by the last grant |
| start_thread | output | THR_W | First hardware thread of the block |
| end_thread | output | THR_W | One past the last hardware thread |
| start_warp | output | WARP_W | First hardware warp of the block |
| end_warp | output | WARP_W | One past the last hardware warp |
| active_cnt | output | CNT_W | Number of busy slots |

## Verification
Every result sits one register stage behind its cause. `grant`, `deny`, the slot ID, and the thread and warp values all appear in the cycle after the request. `active_cnt` reflects the request and any release from the cycle before. The bench drives each stimulus at a falling edge for exactly one cycle and samples at the next falling edge, which is half a period after the capturing rising edge. In the cycles with no grant, it checks that the result outputs still hold their last granted values.

// File: rtl/blk_slot_alloc.sv
module blk_slot_alloc #(
  parameter int MAX_SLOTS        = 32,
  parameter int THREADS_PER_CORE = 2048,
  parameter int WARP_SIZE        = 32,
  localparam int SLOT_W = $clog2(MAX_SLOTS),
  localparam int CNT_W  = SLOT_W + 1,
  localparam int THR_W  = $clog2(THREADS_PER_CORE) + 1,
  localparam int WS_LOG = $clog2(WARP_SIZE),
  localparam int WARP_W = THR_W - WS_LOG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [THR_W-1:0]  blk_threads,
  input  logic [THR_W-1:0]  padded_threads,
  input  logic [CNT_W-1:0]  max_blocks,
  input  logic              rel_valid,
  input  logic [SLOT_W-1:0] rel_slot,
  output logic              grant,
  output logic              deny,
  output logic [SLOT_W-1:0] slot_id,
  output logic [THR_W-1:0]  start_thread,
  output logic [THR_W-1:0]  end_thread,
  output logic [WARP_W-1:0] start_warp,
  output logic [WARP_W-1:0] end_warp,
  output logic [CNT_W-1:0]  active_cnt
);

  logic [MAX_SLOTS-1:0] busy;
  logic [SLOT_W-1:0]    pick;
  logic                 found;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < MAX_SLOTS; i++) begin
      if (!found && !busy[i] && (CNT_W'(i) < max_blocks)) begin
        found = 1'b1;
        pick  = SLOT_W'(i);
      end
    end
  end

  wire alloc  = req && found;
  wire rel_ok = rel_valid && busy[rel_slot];

  wire [THR_W-1:0] start_n = THR_W'(pick) * padded_threads;
  wire [THR_W-1:0] end_n   = start_n + blk_threads;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= '0;
      active_cnt   <= '0;
      grant        <= 1'b0;
      deny         <= 1'b0;
      slot_id      <= '0;
      start_thread <= '0;
      end_thread   <= '0;
      start_warp   <= '0;
      end_warp     <= '0;
    end else begin
      grant <= alloc;
      deny  <= req && !found;
      for (int i = 0; i < MAX_SLOTS; i++) begin
        if (alloc && pick == SLOT_W'(i))
          busy[i] <= 1'b1;
        else if (rel_ok && rel_slot == SLOT_W'(i))
          busy[i] <= 1'b0;
      end
      active_cnt <= active_cnt + CNT_W'(alloc) - CNT_W'(rel_ok);
      if (alloc) begin
        slot_id      <= pick;
        start_thread <= start_n;
        end_thread   <= end_n;
        start_warp   <= WARP_W'(start_n >> WS_LOG);
        end_warp     <= WARP_W'((end_n + THR_W'(WARP_SIZE - 1)) >> WS_LOG);
      end
    end
  end

  assert_slot_in_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (CNT_W'(slot_id) < $past(max_blocks)));

  assert_grant_deny_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));

  assert_deny_keeps_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (deny && !$past(rel_valid)) |-> $stable(active_cnt));

  assert_warp_covers_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ({end_warp, {WS_LOG{1'b0}}} >= end_thread));

  assert_warp_start_below_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ({start_warp, {WS_LOG{1'b0}}} <= start_thread));

  assert_count_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active_cnt <= CNT_W'(MAX_SLOTS));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_cnt == $past(active_cnt)) || (active_cnt == $past(active_cnt) + 1'b1) ||
    (active_cnt + 1'b1 == $past(active_cnt)));

  assert_hold_results_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |-> ($stable(slot_id) && $stable(start_thread) && $stable(end_warp)));

endmodule

// File: tb/blk_slot_alloc_bench.sv
module blk_slot_alloc_bench;
  localparam int SW = 5, CW = 6, TW = 12, WW = 7;

  typedef struct packed {
    logic          rel;
    logic [SW-1:0] rslot;
    logic          rq;
    logic [TW-1:0] blk, pad;
    logic [CW-1:0] mx;
    logic          g, d;
    logic [SW-1:0] slot;
    logic [TW-1:0] st, en;
    logic [WW-1:0] sw, ew;
    logic [CW-1:0] cnt;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b0,5'd0,1'b1,12'd100,12'd128,6'd4, 1'b1,1'b0,5'd0,12'd0,  12'd100,7'd0,7'd4, 6'd1},
    '{1'b0,5'd0,1'b1,12'd100,12'd128,6'd4, 1'b1,1'b0,5'd1,12'd128,12'd228,7'd4,7'd8, 6'd2},
    '{1'b0,5'd0,1'b1,12'd64, 12'd64, 6'd4, 1'b1,1'b0,5'd2,12'd128,12'd192,7'd4,7'd6, 6'd3},
    '{1'b0,5'd0,1'b1,12'd96, 12'd96, 6'd4, 1'b1,1'b0,5'd3,12'd288,12'd384,7'd9,7'd12,6'd4},
    '{1'b0,5'd0,1'b1,12'd96, 12'd96, 6'd4, 1'b0,1'b1,5'd3,12'd288,12'd384,7'd9,7'd12,6'd4},
    '{1'b1,5'd1,1'b0,12'd0,  12'd0,  6'd4, 1'b0,1'b0,5'd3,12'd288,12'd384,7'd9,7'd12,6'd3},
    '{1'b0,5'd0,1'b1,12'd32, 12'd32, 6'd4, 1'b1,1'b0,5'd1,12'd32, 12'd64, 7'd1,7'd2, 6'd4},
    '{1'b1,5'd0,1'b1,12'd100,12'd128,6'd4, 1'b0,1'b1,5'd1,12'd32, 12'd64, 7'd1,7'd2, 6'd3},
    '{1'b1,5'd2,1'b1,12'd40, 12'd64, 6'd4, 1'b1,1'b0,5'd0,12'd0,  12'd40, 7'd0,7'd2, 6'd3},
    '{1'b1,5'd2,1'b0,12'd0,  12'd0,  6'd4, 1'b0,1'b0,5'd0,12'd0,  12'd40, 7'd0,7'd2, 6'd3},
    '{1'b0,5'd0,1'b1,12'd33, 12'd64, 6'd8, 1'b1,1'b0,5'd2,12'd128,12'd161,7'd4,7'd6, 6'd4},
    '{1'b0,5'd0,1'b1,12'd32, 12'd32, 6'd8, 1'b1,1'b0,5'd4,12'd128,12'd160,7'd4,7'd5, 6'd5}
  };

  logic clk = 0, rst_n = 0, req = 0, rel_valid = 0;
  logic [TW-1:0] blk_threads = '0, padded_threads = '0;
  logic [CW-1:0] max_blocks = '0;
  logic [SW-1:0] rel_slot = '0, slot_id;
  logic grant, deny;
  logic [TW-1:0] start_thread, end_thread;
  logic [WW-1:0] start_warp, end_warp;
  logic [CW-1:0] active_cnt;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  blk_slot_alloc u_blk_slot_alloc (
    .clk(clk), .rst_n(rst_n), .req(req), .blk_threads(blk_threads),
    .padded_threads(padded_threads), .max_blocks(max_blocks),
    .rel_valid(rel_valid), .rel_slot(rel_slot), .grant(grant), .deny(deny),
    .slot_id(slot_id), .start_thread(start_thread), .end_thread(end_thread),
    .start_warp(start_warp), .end_warp(end_warp), .active_cnt(active_cnt));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req = 0; rel_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset state
    check("R9 grant", grant, 0);
    check("R9 deny", deny, 0);
    check("R9 count", active_cnt, 0);
    check("R9 slot", slot_id, 0);
    check("R9 start", start_thread, 0);
    check("R9 endwarp", end_warp, 0);

    // table: R1 R3 R4 R5 R6 R10; row 5 R2, row 6 R6 release, rows 8-9 R7, row 10 R8
    for (int k = 0; k < NV; k++) begin
      rel_valid = TBL[k].rel; rel_slot = TBL[k].rslot; req = TBL[k].rq;
      blk_threads = TBL[k].blk; padded_threads = TBL[k].pad; max_blocks = TBL[k].mx;
      @(negedge clk);
      req = 0; rel_valid = 0;
      check($sformatf("R10 grant row%0d", k), grant, TBL[k].g);
      check($sformatf("R2 deny row%0d", k), deny, TBL[k].d);
      check($sformatf("R1 slot row%0d", k), slot_id, TBL[k].slot);
      check($sformatf("R3 start row%0d", k), start_thread, TBL[k].st);
      check($sformatf("R4 end row%0d", k), end_thread, TBL[k].en);
      check($sformatf("R5 swarp row%0d", k), start_warp, TBL[k].sw);
      check($sformatf("R5 ewarp row%0d", k), end_warp, TBL[k].ew);
      check($sformatf("R6 count row%0d", k), active_cnt, TBL[k].cnt);
    end

    // R1 limit above MAX_SLOTS is clamped; R5 top warp reaches 64
    do_reset();
    for (int i = 0; i < 32; i++) begin
      req = 1; blk_threads = 12'd64; padded_threads = 12'd64; max_blocks = 6'd63;
      @(negedge clk);
      req = 0;
      check("R1 fill grant", grant, 1);
      check("R1 fill slot", slot_id, i);
      check("R5 fill swarp", start_warp, 2 * i);
      check("R5 fill ewarp", end_warp, 2 * i + 2);
      check("R6 fill count", active_cnt, i + 1);
    end
    check("R4 last end", end_thread, 2048);
    req = 1;
    @(negedge clk);
    req = 0;
    check("R2 full deny", deny, 1);
    check("R2 full count", active_cnt, 32);
    check("R2 full slot held", slot_id, 31);

    // R1 zero limit allows nothing
    do_reset();
    req = 1; max_blocks = 6'd0; blk_threads = 12'd32; padded_threads = 12'd32;
    @(negedge clk);
    req = 0;
    check("R1 zero-limit deny", deny, 1);
    check("R1 zero-limit grant", grant, 0);
    check("R1 zero-limit count", active_cnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule